// File: doc/BRIEF.md
# Cache-Line Range Maintenance Command Splitter

This block takes one cache maintenance request, given as a start byte address, an end byte address and a two-bit operation code. It turns the request into a stream of commands for a cache controller's command port. The start address is first rounded down to a cache-line boundary. The span from there to the end address is then rounded up to whole lines. That span is cut into range commands, and no command covers more than a per-revision maximum chunk. The commands leave one at a time over a valid/ready handshake. When the span is so large that it has wrapped around the address space, the block sends one whole-cache command in its place. Each request ends with a sync command, and a one-cycle done pulse follows the acceptance of that sync.

The maximum chunk is chosen from the hardware revision input at the moment the request is taken. Older revisions, up to and including a threshold value, are limited to 4 MiB. Newer revisions use a wider limit that is a parameter. In both cases one line is subtracted from the limit, so a chunk is always a whole number of lines and always stays strictly under the limit. The block takes no new request between acceptance and its done pulse.

Top module: `range_op_splitter`

## Requirements
- R1: The first range command of a request carries the start address with its low log2(LINE_BYTES) bits cleared.
- R2: The span `end - aligned_start` (modulo 2^ADDR_W) is rounded up to a multiple of LINE_BYTES. Every range command has a nonzero size that is a multiple of LINE_BYTES and an address that is aligned to a line.
- R3: If the unsigned span before rounding is greater than or equal to 2^ADDR_W - LINE_BYTES, exactly one whole-cache command (kind 1, address 0, size 0) is issued in place of range commands.
- R4: Range commands have size min(remaining, max_chunk). The address advances by each command's size, and the commands stop when the remaining span reaches zero.
- R5: max_chunk equals the limit minus LINE_BYTES. The limit is 4 MiB when rev_id <= 0x16 and NEW_LIMIT (default 2^ADDR_W) otherwise.
- R6: A sync command (kind 2, address 0, size 0) follows the last range command or the whole-cache command. done is high for exactly the one cycle after the sync handshake.
- R7: cmd_kind uses 0 for range, 1 for whole-cache and 2 for sync. cmd_op repeats req_op (0 invalidate, 1 clean, 2 flush) unchanged on every command of the request.
- R8: When end equals the aligned start, no range command is issued and only the sync is sent.
- R9: A req_valid that arrives after a request is accepted and before its done pulse is ignored and adds no commands.
- R10: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and every command field stays stable.
- R11: After reset, cmd_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_start | input | ADDR_W | Start byte address |
| req_end | input | ADDR_W | End byte address (exclusive) |
| req_op | input | 2 | Maintenance operation code |
| rev_id | input | REV_W | Hardware revision, selects the chunk limit |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_kind | output | 2 | 0 range, 1 whole-cache, 2 sync |
| cmd_op | output | 2 | Operation code of the command |
| cmd_addr | output | ADDR_W | Range start address |
| cmd_size | output | ADDR_W | Range size in bytes |
| done | output | 1 | One-cycle pulse once the sync has been accepted |

## Verification
The assertions assume that rev_id and the request fields are meaningful only in the cycle a request is accepted. They also assume that cmd_ready may toggle freely, and that cmd_valid never depends on cmd_ready. The stimulus holds rev_id steady for each whole request. It drives cmd_ready from a pseudo-random pattern that changes just after each rising edge. It issues every real request only after the previous done pulse, apart from the one deliberate strobe that is sent mid-request to check that it is ignored.

// File: rtl/rso_pkg.sv
package rso_pkg;
  typedef enum logic [1:0] {
    CK_RANGE = 2'd0,
    CK_ALL   = 2'd1,
    CK_SYNC  = 2'd2
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RANGE = 2'd1,
    ST_ALL   = 2'd2,
    ST_SYNC  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rso_req_shaper.sv
module rso_req_shaper #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] span_o,
  output logic              whole_o
);
  localparam logic [ADDR_W-1:0] LINE_M1 = ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] LMASK   = ~LINE_M1;
  // two's complement negation of the line size
  localparam logic [ADDR_W-1:0] WRAP_TH = ~LINE_M1;

  logic [ADDR_W-1:0] raw_span;

  always_comb begin
    base_o   = start_i & LMASK;
    raw_span = end_i - base_o;
    whole_o  = (raw_span >= WRAP_TH);
    // no overflow: raw_span < WRAP_TH when used
    span_o   = (raw_span + LINE_M1) & LMASK;
  end
endmodule

// File: rtl/rso_limit_sel.sv
module rso_limit_sel #(
  parameter int              ADDR_W         = 32,
  parameter int              REV_W          = 8,
  parameter int              LINE_BYTES     = 64,
  parameter int              LEGACY_REV_MAX = 'h16,
  parameter longint unsigned LEGACY_LIMIT   = 64'd4194304,
  parameter longint unsigned NEW_LIMIT      = 64'h1_0000_0000
) (
  input  logic [REV_W-1:0]  rev_i,
  output logic [ADDR_W-1:0] max_chunk_o
);
  localparam logic [ADDR_W-1:0] LEG_MAXC = ADDR_W'(LEGACY_LIMIT - 64'(LINE_BYTES));
  localparam logic [ADDR_W-1:0] NEW_MAXC = ADDR_W'(NEW_LIMIT - 64'(LINE_BYTES));
  localparam logic [REV_W-1:0]  REV_TH   = REV_W'(LEGACY_REV_MAX);

  always_comb begin
    max_chunk_o = (rev_i <= REV_TH) ? LEG_MAXC : NEW_MAXC;
  end
endmodule

// File: rtl/rso_chunk_seq.sv
module rso_chunk_seq
  import rso_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] span_i,
  input  logic              whole_i,
  input  logic [ADDR_W-1:0] max_chunk_i,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_size,
  output logic              done
);
  localparam int LB = $clog2(LINE_BYTES);

  seq_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] rem_q;
  logic [ADDR_W-1:0] maxc_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] chunk;
  logic              fire;

  assign fire  = cmd_valid && cmd_ready;
  assign chunk = (rem_q < maxc_q) ? rem_q : maxc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      maxc_q    <= '0;
      op_q      <= '0;
      cmd_valid <= 1'b0;
      cmd_kind  <= CK_RANGE;
      cmd_op    <= '0;
      cmd_addr  <= '0;
      cmd_size  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q <= base_i;
            rem_q  <= span_i;
            maxc_q <= max_chunk_i;
            op_q   <= req_op;
            if (whole_i)            state <= ST_ALL;
            else if (span_i == '0)  state <= ST_SYNC;
            else                    state <= ST_RANGE;
          end
        end
        ST_RANGE: begin
          if (!cmd_valid) begin
            cmd_valid <= 1'b1;
            cmd_kind  <= CK_RANGE;
            cmd_op    <= op_q;
            cmd_addr  <= addr_q;
            cmd_size  <= chunk;
          end else if (cmd_ready) begin
            cmd_valid <= 1'b0;
            addr_q    <= addr_q + cmd_size;
            rem_q     <= rem_q - cmd_size;
            if (rem_q == cmd_size) state <= ST_SYNC;
          end
        end
        ST_ALL: begin
          if (!cmd_valid) begin
            cmd_valid <= 1'b1;
            cmd_kind  <= CK_ALL;
            cmd_op    <= op_q;
            cmd_addr  <= '0;
            cmd_size  <= '0;
          end else if (cmd_ready) begin
            cmd_valid <= 1'b0;
            state     <= ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (!cmd_valid) begin
            cmd_valid <= 1'b1;
            cmd_kind  <= CK_SYNC;
            cmd_op    <= op_q;
            cmd_addr  <= '0;
            cmd_size  <= '0;
          end else if (cmd_ready) begin
            cmd_valid <= 1'b0;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: an offered command is held until taken
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_op)
                                   && $stable(cmd_addr) && $stable(cmd_size)));

  // R2: range commands are nonzero and line aligned
  p_line_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == CK_RANGE) |->
      (cmd_addr[LB-1:0] == '0 && cmd_size[LB-1:0] == '0 && cmd_size != '0));

  // R4: no range command exceeds the latched chunk limit
  p_chunk_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == CK_RANGE) |-> (cmd_size <= maxc_q));

  // R5: the latched limit is a whole number of lines
  p_maxc_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (maxc_q[LB-1:0] == '0 && maxc_q != '0));

  // R6: done follows a taken sync
  p_done_after_sync_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_kind == CK_SYNC) |=> (done && !cmd_valid));

  // R3 / R6: whole-cache and sync commands carry no range
  p_noaddr_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind != CK_RANGE) |-> (cmd_addr == '0 && cmd_size == '0));

  // R7: kind code 3 is never used
  p_kind_legal_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_kind != 2'd3));
endmodule

// File: rtl/range_op_splitter.sv
module range_op_splitter #(
  parameter int              ADDR_W         = 32,
  parameter int              REV_W          = 8,
  parameter int              LINE_BYTES     = 64,
  parameter int              LEGACY_REV_MAX = 'h16,
  parameter longint unsigned LEGACY_LIMIT   = 64'd4194304,
  parameter longint unsigned NEW_LIMIT      = 64'h1_0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic [1:0]        req_op,
  input  logic [REV_W-1:0]  rev_id,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_size,
  output logic              done
);
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] span_w;
  logic              whole_w;
  logic [ADDR_W-1:0] maxc_w;

  rso_req_shaper #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_shape (
    .start_i (req_start),
    .end_i   (req_end),
    .base_o  (base_w),
    .span_o  (span_w),
    .whole_o (whole_w)
  );

  rso_limit_sel #(
    .ADDR_W(ADDR_W), .REV_W(REV_W), .LINE_BYTES(LINE_BYTES),
    .LEGACY_REV_MAX(LEGACY_REV_MAX), .LEGACY_LIMIT(LEGACY_LIMIT), .NEW_LIMIT(NEW_LIMIT)
  ) u_limit (
    .rev_i       (rev_id),
    .max_chunk_o (maxc_w)
  );

  rso_chunk_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .base_i      (base_w),
    .span_i      (span_w),
    .whole_i     (whole_w),
    .max_chunk_i (maxc_w),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_kind    (cmd_kind),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .cmd_size    (cmd_size),
    .done        (done)
  );
endmodule

// File: tb/sim_range_op_splitter.sv
module sim_range_op_splitter;
  localparam int L = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_start = '0;
  logic [31:0] req_end = '0;
  logic [1:0]  req_op = '0;
  logic [7:0]  rev_id = '0;
  logic        cmd_ready = 1'b0;
  logic        cmd_valid;
  logic [1:0]  cmd_kind;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_addr;
  logic [31:0] cmd_size;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0]  k;
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] s;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;  // 125 MHz

  range_op_splitter u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_start(req_start),
    .req_end(req_end), .req_op(req_op), .rev_id(rev_id), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  function automatic void push(logic [1:0] k, logic [1:0] op, logic [31:0] a,
                               logic [31:0] s, string tag);
    exp_t e;
    e.k = k; e.op = op; e.a = a; e.s = s; e.tag = tag;
    q.push_back(e);
  endfunction

  // Reference model built from the requirements
  function automatic void model(logic [31:0] s, logic [31:0] e, logic [1:0] op,
                                logic [7:0] rev);
    logic [31:0] a, sz, maxc, c;
    bit first;
    maxc  = (rev <= 8'h16) ? (32'd4194304 - L) : (32'h0 - L);  // R5
    a     = s & ~32'(L - 1);                                  // R1
    sz    = e - a;
    first = 1;
    if (sz >= (32'h0 - L)) begin
      push(2'd1, op, 0, 0, "R3");                             // R3
    end else begin
      sz = (sz + L - 1) & ~32'(L - 1);                         // R2
      while (sz != 0) begin
        c = (sz < maxc) ? sz : maxc;
        push(2'd0, op, a, c, first ? "R1" : "R4");
        first = 0;
        a  += c;
        sz -= c;
      end
    end
    push(2'd2, op, 0, 0, "R6");
  endfunction

  task automatic run_req(logic [31:0] s, logic [31:0] e, logic [1:0] op,
                         logic [7:0] rev, bit poke_busy);
    model(s, e, op, rev);
    @(negedge clk);
    req_start = s; req_end = e; req_op = op; rev_id = rev; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      // R9: strobe while busy must add nothing
      repeat (3) @(negedge clk);
      req_start = 32'h5000; req_end = 32'h5040; req_op = 2'd1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_start = s; req_end = e; req_op = op;
    end
    while (!done) @(negedge clk);
    chk(q.size() == 0, "R6", $sformatf("queue at done actual=%0d expected=0", q.size()));
    @(negedge clk);
    chk(!done, "R6", $sformatf("done width actual=%0b expected=0", done));
    repeat (4) @(negedge clk);
    chk(!cmd_valid && q.size() == 0, "R9",
        $sformatf("stray output actual valid=%0b left=%0d expected 0/0", cmd_valid, q.size()));
  endtask

  // ready pattern, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1 cmd_ready = ($urandom % 3) != 0;
    end
  end

  // scoreboard monitor
  logic        pv = 0, pr = 0;
  logic [1:0]  pk, po;
  logic [31:0] pa, ps;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (pv && !pr) begin
          chk(cmd_valid && cmd_kind == pk && cmd_op == po && cmd_addr == pa && cmd_size == ps,
              "R10", $sformatf("hold actual=%0b/%0d/%h/%h expected=1/%0d/%h/%h",
                               cmd_valid, cmd_kind, cmd_addr, cmd_size, pk, pa, ps));
        end
        if (cmd_valid && cmd_ready) begin
          if (q.size() == 0) begin
            chk(0, "R9", $sformatf("unexpected cmd actual kind=%0d addr=%h expected none",
                                   cmd_kind, cmd_addr));
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(cmd_kind == e.k && cmd_op == e.op && cmd_addr == e.a && cmd_size == e.s,
                e.tag, $sformatf("R7 cmd actual=%0d/%0d/%h/%h expected=%0d/%0d/%h/%h",
                                 cmd_kind, cmd_op, cmd_addr, cmd_size, e.k, e.op, e.a, e.s));
          end
        end
      end
      pv = cmd_valid; pr = cmd_ready;
      pk = cmd_kind; po = cmd_op; pa = cmd_addr; ps = cmd_size;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !done, "R11", $sformatf("reset actual=%0b/%0b expected=0/0", cmd_valid, done));
    rst = 1'b0;
    @(negedge clk);
    run_req(32'h1000, 32'h1100, 2'd0, 8'h20, 0);      // R4 small aligned
    run_req(32'h1234, 32'h1240, 2'd1, 8'h20, 0);      // R1 start rounded down
    run_req(32'h2000, 32'h2001, 2'd2, 8'h20, 0);      // R2 end rounded up
    run_req(32'h3000, 32'h3000, 2'd1, 8'h20, 0);      // R8 sync only
    run_req(32'h0000_0080, 32'h0000_0040, 2'd2, 8'h20, 0); // R3 wrap
    run_req(32'h0000_0000, 32'hFFFF_FFC0, 2'd0, 8'h30, 0); // R3 at threshold
    run_req(32'h0000_1000, 32'h0000_0000, 2'd1, 8'h30, 0); // just below wrap, new rev
    run_req(32'h0, 32'h0100_0000, 2'd2, 8'h16, 1);    // R5 legacy split, R9 poke
    run_req(32'h0, 32'h0100_0000, 2'd0, 8'h17, 0);    // R5 new rev, one chunk
    run_req(32'h40, 32'h40 + 32'd4194304 - L, 2'd1, 8'h00, 0); // R4 exactly max
    run_req(32'h40, 32'h40 + 32'd4194304, 2'd2, 8'h05, 0);     // R4 max plus a line
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule